// File: doc/BRIEF.md
# UART Receive Character Queue with Interrupt Sources

This block sits behind a UART receive shifter. It holds received characters in a small first-in first-out queue. Each character is stored together with its own break, parity-error and frame-error flags. A FIFO read returns one word: the character, its three flags and a valid bit. Software can drain the queue from an interrupt or by polling a not-empty status bit.

Three interrupt conditions are raised from the queue state:
- an overrun, when a character arrives while the queue is full;
- a fill level above a programmable threshold;
- an idle condition, when the queue has stayed non-empty with no traffic for a programmable number of character times.

Each condition is visible raw in a status vector and is gated by its own mask bit onto a single interrupt line. A receive-enable input decides whether incoming characters are accepted. A queue clear input empties the queue, and it is the only way to remove a latched overrun.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: The queue holds DEPTH (default 16) characters. A character is accepted when `in_valid` and `rx_en` are both high and the queue is not full, and characters are read back in arrival order.
- R2: A read (`pop` high for one cycle on a non-empty queue) presents, from the next cycle until the next read or clear, `rd_word` = {bit 11 valid = 1, bit 10 frame error, bit 9 parity error, bit 8 break, bits 7:0 character}.
- R3: A read of an empty queue sets `rd_word` to all zeros (valid bit 0) and does not advance the read position, so the next stored character is still returned by a later read.
- R4: `irq_status[0]` (overrun) sets when an enabled character arrives while the queue is full, and that character is discarded. Reads do not clear this bit; only `fifo_clr` does.
- R5: `irq_status[1]` is high exactly when the number of stored characters is strictly greater than `thresh`.
- R6: While the queue is non-empty and sees no accepted write and no read, each `char_tick` pulse advances an idle count. `irq_status[2]` sets once the count reaches `idle_limit`, so a value of 1 means one character time. Any write, read, clear or empty queue zeroes the count and the bit, and an `idle_limit` of 0 disables the condition.
- R7: `irq_status[3]` is high whenever the queue is non-empty. It is not maskable and never drives `irq`.
- R8: `irq` is registered and equals, one cycle later, the OR over bits 2:0 of `irq_status & irq_mask`.
- R9: With `rx_en` low, `in_valid` has no effect: nothing is stored and no overrun is raised.
- R10: `fifo_clr` empties the queue, clears overrun and the idle condition, and zeroes `rd_word` in one cycle. It takes priority over a write or read in the same cycle.
- R11: After synchronous reset, `rd_word`, `irq_status` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; gates acceptance of characters |
| in_valid | input | 1 | A deserialized character is offered this cycle |
| in_char | input | 8 | Received character |
| in_brk | input | 1 | Break detected on this character |
| in_par_err | input | 1 | Parity error on this character |
| in_frm_err | input | 1 | Frame error on this character |
| char_tick | input | 1 | One-cycle pulse per character time |
| fifo_clr | input | 1 | Queue clear; also removes overrun |
| pop | input | 1 | Read one entry from the queue |
| thresh | input | LW | Fill threshold; status when level > thresh |
| idle_limit | input | TW | Idle timeout in character times; 0 disables |
| irq_mask | input | 3 | Per-source enable: 0 overrun, 1 threshold, 2 idle |
| rd_word | output | 12 | Last read word: valid, flags, character |
| irq_status | output | 4 | Raw status: 0 overrun, 1 above threshold, 2 idle, 3 not empty |
| irq | output | 1 | Masked, registered interrupt line |

## Verification
The bench builds the block with its default sizes: a depth of 16 and a 4-bit idle counter. A depth of 16 lets a few hundred random cycles reach a full queue, an overrun and many pointer wrap-arounds. The 4-bit counter lets idle limits from 1 to 5 character times expire often, alongside ticks arriving during traffic. Directed steps add a write offered on a full queue with a read in the same cycle, an empty read, a disabled receiver, a limit of one character time, and a clear colliding with a write.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // one stored queue entry: flags above the character
  typedef struct packed {
    logic       frm;
    logic       par;
    logic       brk;
    logic [7:0] ch;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
  localparam int WORD_W  = ENTRY_W + 1;

  // status vector bit positions
  localparam int ST_OVR  = 0;
  localparam int ST_THR  = 1;
  localparam int ST_IDLE = 2;
  localparam int ST_NE   = 3;
  localparam int N_SRC   = 3;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  rx_entry_t         din,
  output logic [LW-1:0]     level,
  output logic              overrun,
  output logic [WORD_W-1:0] rd_word,
  output logic              activity
);
  logic [AW-1:0] wp, rp;
  rx_entry_t     mem [DEPTH];
  rx_entry_t     mem_q;
  logic          hit;
  logic          full, empty, do_wr, do_rd;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign do_wr    = push && !full && !clr;
  assign do_rd    = pop && !empty && !clr;
  assign activity = do_wr || do_rd;

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_rd) mem_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      overrun <= 1'b0;
      hit     <= 1'b0;
    end else begin
      if (do_wr) wp <= step_ptr(wp);
      if (do_rd) rp <= step_ptr(rp);
      level <= level + LW'(do_wr) - LW'(do_rd);
      if (push && full) overrun <= 1'b1;
      if (pop) hit <= do_rd;
    end
  end

  assign rd_word = hit ? {1'b1, mem_q} : '0;

  // R1: occupancy never passes the depth
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R4: overrun survives everything except a clear
  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clr) |=> overrun);
  // R10: clear empties the queue and drops overrun at once
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0 && !overrun && rd_word[WORD_W-1] == 1'b0));
  // R3: an empty read yields no valid word and leaves the read position
  assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !clr) |=> (rd_word[WORD_W-1] == 1'b0 && $stable(rp)));
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          activity,
  input  logic          nonempty,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr || activity || !nonempty) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (tick && !expired && limit != '0) begin
      cnt <= cnt_inc[TW-1:0];
      if (cnt_inc >= {1'b0, limit}) expired <= 1'b1;
    end
  end

  // R6: the idle condition only exists on a non-empty queue
  assert_idle_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    expired |-> nonempty);
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import rxf_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int TW    = 4,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  input  logic              in_brk,
  input  logic              in_par_err,
  input  logic              in_frm_err,
  input  logic              char_tick,
  input  logic              fifo_clr,
  input  logic              pop,
  input  logic [LW-1:0]     thresh,
  input  logic [TW-1:0]     idle_limit,
  input  logic [N_SRC-1:0]  irq_mask,
  output logic [WORD_W-1:0] rd_word,
  output logic [3:0]        irq_status,
  output logic              irq
);
  rx_entry_t     din;
  logic [LW-1:0] level;
  logic          overrun, activity, expired, nonempty, push;

  assign din      = '{frm: in_frm_err, par: in_par_err, brk: in_brk, ch: in_char};
  assign push     = in_valid && rx_en;
  assign nonempty = (level != '0);

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (fifo_clr),
    .push     (push),
    .pop      (pop),
    .din      (din),
    .level    (level),
    .overrun  (overrun),
    .rd_word  (rd_word),
    .activity (activity)
  );

  rxf_idle_timer #(.TW(TW)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .clr      (fifo_clr),
    .activity (activity),
    .nonempty (nonempty),
    .tick     (char_tick),
    .limit    (idle_limit),
    .expired  (expired)
  );

  always_comb begin
    irq_status          = '0;
    irq_status[ST_OVR]  = overrun;
    irq_status[ST_THR]  = (level > thresh);
    irq_status[ST_IDLE] = expired;
    irq_status[ST_NE]   = nonempty;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(irq_status[N_SRC-1:0] & irq_mask);
  end

  // R9: a disabled receiver stores nothing
  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !pop && !fifo_clr) |=> $stable(level));
  // R7: not-empty alone never raises the line
  assert_ne_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_status[N_SRC-1:0] == '0) |=> !irq);
endmodule

// File: tb/uart_rx_fifo_irq_bench.sv
module uart_rx_fifo_irq_bench;
  localparam int DEPTH = 16;
  localparam int TW    = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          en = 1'b0, vin = 1'b0, brk = 1'b0, par = 1'b0, frm = 1'b0;
  logic [7:0]    ch = '0;
  logic          tick = 1'b0, clr = 1'b0, pop = 1'b0;
  logic [LW-1:0] thresh = '0;
  logic [TW-1:0] lim = '0;
  logic [2:0]    msk = '0;
  logic [11:0]   rd_word;
  logic [3:0]    st;
  logic          irq;

  uart_rx_fifo_irq #(.DEPTH(DEPTH), .TW(TW)) u_uart_rx_fifo_irq (
    .clk(clk), .rst(rst), .rx_en(en), .in_valid(vin), .in_char(ch),
    .in_brk(brk), .in_par_err(par), .in_frm_err(frm), .char_tick(tick),
    .fifo_clr(clr), .pop(pop), .thresh(thresh), .idle_limit(lim),
    .irq_mask(msk), .rd_word(rd_word), .irq_status(st), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [10:0] mq[$];
  logic        mo = 1'b0, mt = 1'b0, mirq = 1'b0;
  int          mc = 0;
  logic [11:0] mrd = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] mstat();
    return {mq.size() != 0, mt, mq.size() > int'(thresh), mo};
  endfunction

  task automatic step();
    logic [3:0] ps;
    logic full, emp, act;
    @(posedge clk);
    ps = mstat();
    if (rst) begin
      mq.delete(); mo = 0; mt = 0; mc = 0; mrd = '0; mirq = 0;
    end else begin
      mirq = |(ps[2:0] & msk);
      if (clr) begin
        mq.delete(); mo = 0; mt = 0; mc = 0; mrd = '0;
      end else begin
        full = (mq.size() == DEPTH);
        emp  = (mq.size() == 0);
        act  = 0;
        if (pop) begin
          if (!emp) begin
            mrd = {1'b1, mq[0]};
            void'(mq.pop_front());
            act = 1;
          end else mrd = '0;
        end
        if (vin && en) begin
          if (full) mo = 1;
          else begin mq.push_back({frm, par, brk, ch}); act = 1; end
        end
        if (act || emp) begin mc = 0; mt = 0; end
        else if (tick && !mt && lim != 0) begin
          mc++;
          if (mc >= int'(lim)) mt = 1;
        end
      end
    end
    @(negedge clk);
    if (!rst) begin
      ps = mstat();
      chk(mrd[11] ? "R1/R2" : "R3", "rd_word", 32'(rd_word), 32'(mrd));
      chk("R4", "overrun", 32'(st[0]), 32'(ps[0]));
      chk("R5", "above_thresh", 32'(st[1]), 32'(ps[1]));
      chk("R6", "idle", 32'(st[2]), 32'(ps[2]));
      chk("R7", "not_empty", 32'(st[3]), 32'(ps[3]));
      chk("R8", "irq", 32'(irq), 32'(mirq));
    end
  endtask

  task automatic drive(input bit v, input bit p, input bit c, input bit t);
    vin = v; pop = p; clr = c; tick = t;
    ch  = 8'($urandom); brk = 1'($urandom); par = 1'($urandom); frm = 1'($urandom);
    step();
    vin = 0; pop = 0; clr = 0; tick = 0;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    @(negedge clk);
    step(); step();
    // R11: outputs zero under reset
    chk("R11", "rd_word", 32'(rd_word), 0);
    chk("R11", "status", 32'(st), 0);
    chk("R11", "irq", 32'(irq), 0);
    rst = 1'b0;
    en = 1; msk = 3'b111; thresh = LW'(8); lim = '0;
    step();

    // R1 / R5: fill to the brim
    for (int i = 0; i < DEPTH; i++) drive(1, 0, 0, 0);
    chk("R7", "full not_empty", 32'(st[3]), 1);
    chk("R5", "full above_thresh", 32'(st[1]), 1);
    // R4: write on full with a read in the same cycle still overruns
    drive(1, 1, 0, 0);
    chk("R4", "overrun set", 32'(st[0]), 1);
    drive(0, 1, 0, 0);
    chk("R4", "overrun kept after read", 32'(st[0]), 1);
    // R3: drain and read once more
    for (int i = 0; i < DEPTH; i++) drive(0, 1, 0, 0);
    chk("R3", "empty read word", 32'(rd_word), 0);
    // R9: disabled receiver
    en = 0;
    drive(1, 0, 0, 0);
    chk("R9", "nothing stored", 32'(st[3]), 0);
    en = 1;
    // R6: one character time
    lim = TW'(1);
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 1);
    chk("R6", "idle after one tick", 32'(st[2]), 1);
    // R10: clear beats a write
    drive(1, 0, 1, 0);
    chk("R10", "status after clear", 32'(st), 0);
    drive(0, 1, 0, 0);
    chk("R10", "nothing behind clear", 32'(rd_word), 0);

    // random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 200 == 0) begin
        lim    = TW'($urandom_range(0, 5));
        thresh = LW'($urandom_range(0, DEPTH));
        msk    = 3'($urandom);
        en     = ($urandom_range(0, 9) != 0);
      end
      drive($urandom_range(0, 99) < 50, $urandom_range(0, 99) < 42,
            $urandom_range(0, 199) == 0, $urandom_range(0, 3) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule